// File: doc/BRIEF.md
# Reference-Aligned Frame and Multiframe Counter

This block keeps a frame counter and a multiframe counter running in the device-clock domain. It also sets their phase from an external timing reference. The reference input is registered on the device clock, and only a rising transition of the registered value is used. Once a programmable number of device clocks has passed after that transition, both counters restart from zero. The frame boundary and the multiframe boundary then fall a known, repeatable number of cycles after the reference edge.

A frame is `cfg_frame_m1 + 1` device clocks long, and a multiframe is `cfg_mf_m1 + 1` frames long. The reference may be a single pulse, a continuous square wave, or a square wave with gaps. Its period is a whole number of multiframes, so later edges normally land on a boundary that already exists. When an edge lands off that boundary, a phase-error flag is raised, and the counters move to the new phase only if realignment is enabled. A separate one-cycle mark flags the sample taken at the reference edge, so that a control bit can be set in that sample.

A mode input can select the active-low link synchronisation input as the timing source instead. In that mode, the deassertion of that input restarts the frame counter after the same programmable delay.

Top module: `mfclk_align`

## Requirements
- R1: While reset is applied and in the first cycle after it is released, `frame_tick` and `mf_tick` are 1 (both counters at zero), and `ref_mark` and `phase_err` are 0.
- R2: `ref_mark` is 1 for exactly one cycle. That cycle starts at the clock edge that first registers `ref_in` high after it was registered low, in either timing-source mode.
- R3: While no realignment occurs, `frame_tick` is 1 once every `cfg_frame_m1+1` cycles. `mf_tick` is 1 on every `cfg_mf_m1+1`-th frame tick and never without `frame_tick`.
- R4: With `sel_sync`=0, the first reference edge after reset restarts both counters. `frame_tick` and `mf_tick` are both 1 exactly `cfg_delay+1` cycles after the `ref_mark` cycle. The counters then run from that phase.
- R5: A reference held high produces one alignment event only. The counter phase and `ref_mark` stay unchanged for as long as the level stays high.
- R6: A later reference edge whose restart would coincide with an existing multiframe boundary leaves the counter phase unchanged and sets `phase_err` to 0. This covers periodic, gapped and single-pulse references.
- R7: A later reference edge whose restart point is not a multiframe boundary sets `phase_err` to 1. With `realign_en`=1, the counters restart at that point. `phase_err` stays 1 until the next on-boundary reference edge.
- R8: With `realign_en`=0, an off-boundary reference edge after the first alignment sets `phase_err` to 1 and leaves the counter phase unchanged.
- R9: With `sel_sync`=1, a registered rising transition of `sync_n` restarts only the frame counter. `frame_tick` is 1 exactly `cfg_delay+1` cycles after the cycle in which that transition is registered, and the multiframe count continues from its old value. Reference edges do not move the counters in this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | External timing reference, asynchronous level |
| sync_n | input | 1 | Active-low link synchronisation input |
| sel_sync | input | 1 | Timing source: 0 = reference edge, 1 = sync_n deassertion |
| realign_en | input | 1 | Allow an off-boundary reference edge to move the counters |
| cfg_frame_m1 | input | FW | Frame length in device clocks, minus one |
| cfg_mf_m1 | input | KW | Multiframe length in frames, minus one |
| cfg_delay | input | DW | Device clocks from registered edge to restart |
| frame_tick | output | 1 | First device clock of a frame |
| mf_tick | output | 1 | First device clock of a multiframe |
| ref_mark | output | 1 | Marks the sample registered at a reference edge |
| phase_err | output | 1 | Last reference edge after alignment was off-boundary |

## Verification
The hardest situation to reach from the ports is an off-boundary reference edge once the counters are already locked. This case matters most with realignment disabled, because the counters must keep their old phase while the flag rises. The bench first locks the counters with a single edge. It then counts cycles from a known multiframe boundary and raises the reference two cycles later, which places the restart point seven cycles into a sixteen-cycle multiframe. A square-wave reference placed exactly on the boundary then clears the flag. Sync mode is reached in the same way, from a counted boundary, so that the shifted frame ticks and the unchanged multiframe count can be predicted.

// File: rtl/mfclk_pkg.sv
package mfclk_pkg;
    typedef enum logic {
        SRC_REF  = 1'b0,
        SRC_SYNC = 1'b1
    } src_e;
endpackage

// File: rtl/mfclk_edge.sv
// Registers W asynchronous levels and flags a rising transition of each.
module mfclk_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_in,
    output logic [W-1:0] rise
);
    typedef struct packed {
        logic [W-1:0] cur;
        logic [W-1:0] prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.cur  = lvl_in;
        st_d.prev = st_q.cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < W; g++) begin : g_rise
        assign rise[g] = st_q.cur[g] & ~st_q.prev[g];
    end
endmodule

// File: rtl/mfclk_delay.sv
// Fixed programmable delay from a trigger to a restart strobe.
module mfclk_delay #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig,
    input  logic [DW-1:0] cfg_delay,
    output logic          fire
);
    typedef struct packed {
        logic          pend;
        logic [DW-1:0] cnt;
    } dly_st_t;

    dly_st_t st_d, st_q;
    logic    zero_dly;

    always_comb begin
        st_d     = st_q;
        zero_dly = (cfg_delay == '0);
        fire     = (trig && zero_dly) || (st_q.pend && st_q.cnt == DW'(1));
        if (st_q.pend) begin
            if (st_q.cnt <= DW'(1)) st_d.pend = 1'b0;
            else                    st_d.cnt  = st_q.cnt - DW'(1);
        end
        if (trig && !zero_dly) begin
            st_d.pend = 1'b1;
            st_d.cnt  = cfg_delay;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/mfclk_counters.sv
// Frame and multiframe counters with boundary check on each restart strobe.
module mfclk_counters
    import mfclk_pkg::*;
#(
    parameter int FW = 5,
    parameter int KW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  src_e          src,
    input  logic          realign_en,
    input  logic [FW-1:0] cfg_frame_m1,
    input  logic [KW-1:0] cfg_mf_m1,
    output logic          frame_tick,
    output logic          mf_tick,
    output logic          phase_err
);
    typedef struct packed {
        logic [FW-1:0] fc;
        logic [KW-1:0] mc;
        logic          locked;
        logic          err;
    } cnt_st_t;

    cnt_st_t       st_d, st_q;
    logic          fr_end, mf_end, on_bnd;
    logic [FW-1:0] fc_adv;
    logic [KW-1:0] mc_adv;

    always_comb begin
        fr_end = (st_q.fc >= cfg_frame_m1);
        mf_end = (st_q.mc >= cfg_mf_m1);
        on_bnd = fr_end && mf_end;
        fc_adv = fr_end ? '0 : st_q.fc + FW'(1);
        mc_adv = !fr_end ? st_q.mc : (mf_end ? '0 : st_q.mc + KW'(1));

        st_d    = st_q;
        st_d.fc = fc_adv;
        st_d.mc = mc_adv;

        if (fire) begin
            if (src == SRC_SYNC) begin
                st_d.fc = '0;
            end else if (!st_q.locked) begin
                st_d.fc     = '0;
                st_d.mc     = '0;
                st_d.locked = 1'b1;
                st_d.err    = 1'b0;
            end else if (on_bnd) begin
                st_d.err = 1'b0;
            end else begin
                st_d.err = 1'b1;
                if (realign_en) begin
                    st_d.fc = '0;
                    st_d.mc = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frame_tick = (st_q.fc == '0);
    assign mf_tick    = frame_tick && (st_q.mc == '0);
    assign phase_err  = st_q.err;
endmodule

// File: rtl/mfclk_align.sv
module mfclk_align
    import mfclk_pkg::*;
#(
    parameter int FW = 5,
    parameter int KW = 5,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_in,
    input  logic          sync_n,
    input  logic          sel_sync,
    input  logic          realign_en,
    input  logic [FW-1:0] cfg_frame_m1,
    input  logic [KW-1:0] cfg_mf_m1,
    input  logic [DW-1:0] cfg_delay,
    output logic          frame_tick,
    output logic          mf_tick,
    output logic          ref_mark,
    output logic          phase_err
);
    localparam int NSRC    = 2;
    localparam int IDX_REF = 0;
    localparam int IDX_SYN = 1;

    logic [NSRC-1:0] rise;
    logic            trig;
    logic            fire;
    src_e            src;

    assign src = src_e'(sel_sync);

    mfclk_edge #(.W(NSRC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_in ({sync_n, ref_in}),
        .rise   (rise)
    );

    assign ref_mark = rise[IDX_REF];
    assign trig     = (src == SRC_SYNC) ? rise[IDX_SYN] : rise[IDX_REF];

    mfclk_delay #(.DW(DW)) u_delay (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .cfg_delay (cfg_delay),
        .fire      (fire)
    );

    mfclk_counters #(.FW(FW), .KW(KW)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .fire         (fire),
        .src          (src),
        .realign_en   (realign_en),
        .cfg_frame_m1 (cfg_frame_m1),
        .cfg_mf_m1    (cfg_mf_m1),
        .frame_tick   (frame_tick),
        .mf_tick      (mf_tick),
        .phase_err    (phase_err)
    );
endmodule

// File: rtl/mfclk_align_chk.sv
module mfclk_align_chk (
    input logic clk,
    input logic rst_n,
    input logic frame_tick,
    input logic mf_tick,
    input logic ref_mark,
    input logic phase_err,
    input logic fire,
    input logic sel_sync,
    input logic realign_en
);
    // R3
    a_r3_mf_within_frame: assert property (@(posedge clk) disable iff (!rst_n)
        mf_tick |-> frame_tick);

    // R2
    a_r2_mark_single: assert property (@(posedge clk) disable iff (!rst_n)
        ref_mark |=> !ref_mark);

    // R4 and R7: a reference restart with realignment allowed lands on a multiframe boundary
    a_r4_restart_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !sel_sync && realign_en) |=> (frame_tick && mf_tick));

    // R9
    a_r9_sync_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && sel_sync) |=> frame_tick);

    // R7: the flag changes only after a reference-mode restart strobe
    a_r7_err_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase_err) |-> $past(fire && !sel_sync));
endmodule

bind mfclk_align mfclk_align_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .mf_tick    (mf_tick),
    .ref_mark   (ref_mark),
    .phase_err  (phase_err),
    .fire       (fire),
    .sel_sync   (sel_sync),
    .realign_en (realign_en)
);

// File: tb/mfclk_align_tb.sv
module mfclk_align_tb;
    localparam int FW = 5;
    localparam int KW = 5;
    localparam int DW = 8;
    localparam int FLEN = 4;
    localparam int MLEN = 16;
    localparam int DLY  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_in = 1'b0;
    logic          sync_n = 1'b0;
    logic          sel_sync = 1'b0;
    logic          realign_en = 1'b1;
    logic [FW-1:0] cfg_frame_m1 = FW'(FLEN - 1);
    logic [KW-1:0] cfg_mf_m1 = KW'(MLEN / FLEN - 1);
    logic [DW-1:0] cfg_delay = DW'(DLY);
    logic          frame_tick, mf_tick, ref_mark, phase_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mfclk_align #(.FW(FW), .KW(KW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .sync_n(sync_n),
        .sel_sync(sel_sync), .realign_en(realign_en),
        .cfg_frame_m1(cfg_frame_m1), .cfg_mf_m1(cfg_mf_m1), .cfg_delay(cfg_delay),
        .frame_tick(frame_tick), .mf_tick(mf_tick), .ref_mark(ref_mark),
        .phase_err(phase_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick_chk(input string req, input int pos);
        chk(frame_tick == (pos % FLEN == 0), req, frame_tick, int'(pos % FLEN == 0));
        chk(mf_tick == (pos % MLEN == 0), req, mf_tick, int'(pos % MLEN == 0));
    endtask

    // Starts at a multiframe boundary negedge; ends at one when n is a multiple of MLEN.
    // sq=1 drives a reference square wave whose edges restart exactly on boundaries.
    task automatic run_pattern(input int n, input bit sq, input int err_exp, input string req);
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            tick_chk(req, i);
            if (err_exp >= 0) chk(phase_err == err_exp[0], req, phase_err, err_exp);
            if (sq) ref_in = (i >= 11) && (((i + 5) % MLEN) < 8);
        end
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        chk(frame_tick == 1'b1, "R1 frame_tick in reset", frame_tick, 1);
        chk(mf_tick == 1'b1, "R1 mf_tick in reset", mf_tick, 1);
        chk(ref_mark == 1'b0, "R1 ref_mark in reset", ref_mark, 0);
        chk(phase_err == 1'b0, "R1 phase_err in reset", phase_err, 0);
        rst_n = 1'b1;
        #0.5;
        chk(frame_tick && mf_tick, "R1 position zero after release", frame_tick, 1);
    endtask

    task automatic test_freerun();
        run_pattern(2 * MLEN, 1'b0, 0, "R3 free-running ticks");
    endtask

    task automatic test_first_align();
        @(negedge clk); @(negedge clk);
        ref_in = 1'b1;
        @(negedge clk);
        chk(ref_mark == 1'b1, "R2 mark after edge", ref_mark, 1);
        @(negedge clk);
        chk(ref_mark == 1'b0, "R2 mark one cycle", ref_mark, 0);
        repeat (DLY - 1) @(negedge clk);
        chk(frame_tick == 1'b0, "R4 no early boundary", frame_tick, 0);
        @(negedge clk);
        chk(frame_tick && mf_tick, "R4 boundary at delay+1", int'(frame_tick && mf_tick), 1);
        chk(phase_err == 1'b0, "R4 first lock no error", phase_err, 0);
        for (int i = 1; i <= 2 * MLEN; i++) begin
            @(negedge clk);
            tick_chk("R5 held level keeps phase", i);
            chk(ref_mark == 1'b0, "R5 no mark while held", ref_mark, 1'b0);
        end
        ref_in = 1'b0;
    endtask

    task automatic test_periodic();
        run_pattern(3 * MLEN, 1'b1, 0, "R6 periodic on boundary");
        ref_in = 1'b0;
        run_pattern(2 * MLEN, 1'b0, 0, "R6 gap in reference");
        run_pattern(MLEN, 1'b1, 0, "R6 single pulse on boundary");
        ref_in = 1'b0;
        run_pattern(MLEN, 1'b0, 0, "R6 phase kept");
    endtask

    task automatic test_off_boundary();
        realign_en = 1'b1;
        @(negedge clk); @(negedge clk);
        ref_in = 1'b1;
        for (int i = 3; i <= 7; i++) begin
            @(negedge clk);
            if (i < 7) tick_chk("R7 old phase before restart", i);
        end
        chk(frame_tick && mf_tick, "R7 realigned boundary", int'(frame_tick && mf_tick), 1);
        chk(phase_err == 1'b1, "R7 error raised", phase_err, 1);
        ref_in = 1'b0;
        run_pattern(MLEN, 1'b0, 1, "R7 error held, new phase");
        run_pattern(MLEN, 1'b1, -1, "R7 new phase with clearing edge");
        chk(phase_err == 1'b0, "R7 error cleared on boundary edge", phase_err, 0);
        ref_in = 1'b0;
        run_pattern(MLEN, 1'b0, 0, "R7 stays clear");
    endtask

    task automatic test_no_realign();
        realign_en = 1'b0;
        @(negedge clk); @(negedge clk);
        ref_in = 1'b1;
        for (int i = 3; i <= MLEN; i++) begin
            @(negedge clk);
            tick_chk("R8 phase unchanged", i);
            if (i >= 7) chk(phase_err == 1'b1, "R8 error raised", phase_err, 1);
        end
        ref_in = 1'b0;
        realign_en = 1'b1;
        run_pattern(MLEN, 1'b1, -1, "R8 phase unchanged");
        chk(phase_err == 1'b0, "R8 error cleared", phase_err, 0);
        ref_in = 1'b0;
    endtask

    task automatic test_sync();
        bit fexp, mexp;
        sel_sync = 1'b1;
        sync_n = 1'b0;
        @(negedge clk);
        sync_n = 1'b1;
        for (int i = 2; i <= 34; i++) begin
            @(negedge clk);
            fexp = (i == 4) || ((i >= 6) && ((i - 6) % FLEN == 0));
            mexp = (i == 18) || (i == 34);
            chk(frame_tick == fexp, "R9 frame restart from sync", frame_tick, fexp);
            chk(mf_tick == mexp, "R9 multiframe continues", mf_tick, mexp);
            if (i == 7) ref_in = 1'b1;
            if (i == 8) chk(ref_mark == 1'b1, "R2 mark in sync mode", ref_mark, 1);
        end
        ref_in = 1'b0;
        sel_sync = 1'b0;
    endtask

    initial begin
        test_reset();
        test_freerun();
        test_first_align();
        test_periodic();
        test_off_boundary();
        test_no_realign();
        test_sync();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule